// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a 32-bit processor whose instructions are one word long and word aligned. On every step it looks at the fetched instruction and picks one of four next addresses:

- the sequential address, which is the current PC plus four;
- a PC-relative branch target, taken only when the equal or not-equal condition holds;
- an absolute jump target, built inside the current 256 MB region;
- a register value, for register-indirect jumps.

For jump-and-link it also asks the register file to write the return address into the link register.

The surrounding core does three things for it. It compares the two source registers and supplies the equality result. It supplies the value read from the first source register. It raises the step enable when an instruction is ready to retire. The PC register moves only on a rising clock edge with the step enable high. The link request is combinational with the step, so the register file can commit it on the same edge that advances the PC. There are no delay slots: a taken transfer takes effect on the very next step.

Top module: `npc_unit`

## Requirements
- R1: After reset the PC output equals the START_PC parameter (default 0x00400000).
- R2: An instruction that is not a control transfer gives a next PC of PC+4 and no link request. This covers any opcode other than 0, 2, 3, 4 and 5, and also opcode 0 (bits 31:26) with a function field (bits 5:0) other than 8.
- R3: Opcode 4 (branch on equal) with the equality flag high gives a next PC of (PC+4) + the 16-bit offset in bits 15:0, shifted left by two and sign-extended to 32 bits.
- R4: Opcode 4 with the equality flag low gives a next PC of PC+4.
- R5: Opcode 5 (branch on not equal) uses the same target as R3 when the equality flag is low, and PC+4 when it is high. A negative offset (bit 15 set) moves the PC backwards.
- R6: Opcode 2 (jump) gives a next PC of {(PC+4)[31:28], bits 25:0, 2'b00}. The upper four bits come from PC+4, even when PC+4 crosses into the next 256 MB region.
- R7: Opcode 3 (jump and link) uses the R6 target. It raises the link request with register index 31 and link data equal to PC+4.
- R8: Opcode 0 with function 8 (jump register) gives a next PC equal to the register-read input. In every other case that input has no effect.
- R9: While the step enable is low the PC holds its value, whatever the instruction is.
- R10: The link request is high only when the step enable is high and the instruction is a jump-and-link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance the PC this cycle |
| instr | input | 32 | Fetched instruction word |
| rs_val | input | 32 | Value of the first source register |
| rs_equal | input | 1 | High when both source registers are equal |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded on the next enabled step |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Index of the link register (31) |
| link_data | output | 32 | Return address, PC+4 |

## Verification
The bench builds the unit with its default parameters: START_PC at 0x00400000 and a four-bit region field. From that start, a single jump reaches 0x00400020, the address where the branch sequence begins. A jump register to 0x0FFFFFFC then places the next sequential address at 0x10000000. This lets the jump splice cross a 256 MB boundary with the default widths. Negative branch offsets and unknown opcodes are reached through the same table of vectors.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned OP_W      = 6;
    localparam int unsigned FN_W      = 6;
    localparam int unsigned OFF_W     = 16;
    localparam int unsigned JADDR_W   = 26;
    localparam int unsigned REG_IDX_W = 5;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OP_JUMP    = 6'd2;
    localparam logic [OP_W-1:0] OP_JLINK   = 6'd3;
    localparam logic [OP_W-1:0] OP_BREQ    = 6'd4;
    localparam logic [OP_W-1:0] OP_BRNE    = 6'd5;
    localparam logic [FN_W-1:0] FN_JREG    = 6'd8;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BREQ,
        FLOW_BRNE,
        FLOW_JUMP,
        FLOW_JLINK,
        FLOW_JREG
    } flow_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } pc_state_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output flow_e           flow
);

    always_comb begin
        unique case (opcode)
            OP_BREQ:    flow = FLOW_BREQ;
            OP_BRNE:    flow = FLOW_BRNE;
            OP_JUMP:    flow = FLOW_JUMP;
            OP_JLINK:   flow = FLOW_JLINK;
            OP_SPECIAL: flow = (funct == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default:    flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int unsigned REGION_W = 4
) (
    input  logic [XLEN-1:0]    pc_cur,
    input  logic [JADDR_W-1:0] field26,
    output logic [XLEN-1:0]    pc_plus4,
    output logic [XLEN-1:0]    br_target,
    output logic [XLEN-1:0]    jmp_target
);

    localparam int unsigned SEXT_W = XLEN - OFF_W - 2;

    logic [OFF_W-1:0] off16;
    logic [XLEN-1:0]  off_bytes;

    always_comb begin
        off16      = field26[OFF_W-1:0];
        pc_plus4   = pc_cur + XLEN'(4);
        off_bytes  = {{SEXT_W{off16[OFF_W-1]}}, off16, 2'b00};
        br_target  = pc_plus4 + off_bytes;
        jmp_target = {pc_plus4[XLEN-1 -: REGION_W], field26, 2'b00};
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] START_PC = 32'h0040_0000,
    parameter int unsigned LINK_REG = 31,
    parameter int unsigned REGION_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_en,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic        rs_equal,
    output logic [31:0] pc,
    output logic [31:0] next_pc,
    output logic        link_we,
    output logic [4:0]  link_idx,
    output logic [31:0] link_data
);

    pc_state_t st_d, st_q;
    flow_e     flow;
    logic [XLEN-1:0] pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] npc;

    npc_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .flow   (flow)
    );

    npc_target #(.REGION_W(REGION_W)) u_target (
        .pc_cur     (st_q.pc),
        .field26    (instr[JADDR_W-1:0]),
        .pc_plus4   (pc_plus4),
        .br_target  (br_target),
        .jmp_target (jmp_target)
    );

    always_comb begin
        unique case (flow)
            FLOW_BREQ:  npc = rs_equal  ? br_target : pc_plus4;
            FLOW_BRNE:  npc = !rs_equal ? br_target : pc_plus4;
            FLOW_JUMP:  npc = jmp_target;
            FLOW_JLINK: npc = jmp_target;
            FLOW_JREG:  npc = rs_val;
            default:    npc = pc_plus4;
        endcase
        st_d = st_q;
        if (step_en) begin
            st_d.pc = npc;
        end
        next_pc   = npc;
        link_we   = step_en && (flow == FLOW_JLINK);
        link_idx  = REG_IDX_W'(LINK_REG);
        link_data = pc_plus4;
        pc        = st_q.pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc <= START_PC;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: PC frozen while not stepping
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pc));

    // R2: sequential flow advances by one word
    p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && instr[31:26] > OP_BRNE) |=> pc == $past(pc) + 32'd4);

    // R8: register jump lands on the register value
    p_jreg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && instr[31:26] == OP_SPECIAL && instr[5:0] == FN_JREG)
        |=> pc == $past(rs_val));

    // R7: link carries return address into register 31
    p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data == pc + 32'd4 && link_idx == 5'd31));

    // R10: link request only for a stepping jump-and-link
    p_link_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (step_en && instr[31:26] == OP_JLINK));

    // R4: equal-branch with flag low falls through
    p_beq_nt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && instr[31:26] == OP_BREQ && !rs_equal)
        |=> pc == $past(pc) + 32'd4);

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic        rs_equal = 1'b0;
    logic [31:0] pc, next_pc, link_data;
    logic        link_we;
    logic [4:0]  link_idx;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    npc_unit u_npc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .instr     (instr),
        .rs_val    (rs_val),
        .rs_equal  (rs_equal),
        .pc        (pc),
        .next_pc   (next_pc),
        .link_we   (link_we),
        .link_idx  (link_idx),
        .link_data (link_data)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] rsv;
        logic        eq;
        logic [31:0] exp_pc;
        logic        exp_link;
        logic [31:0] exp_ldata;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0810_0008, 32'h0,         1'b0, 32'h0040_0020, 1'b0, 32'h0},          // R6 jump to 0x00400020
        '{32'h1211_0002, 32'h0,         1'b1, 32'h0040_002C, 1'b0, 32'h0},          // R3 beq taken
        '{32'h1611_0005, 32'h0,         1'b1, 32'h0040_0030, 1'b0, 32'h0},          // R5 bne not taken
        '{32'h1211_0002, 32'h0,         1'b0, 32'h0040_0034, 1'b0, 32'h0},          // R4 beq not taken
        '{32'h1611_FFFD, 32'h0,         1'b0, 32'h0040_002C, 1'b0, 32'h0},          // R5 bne taken, negative
        '{32'h0211_9820, 32'h1234_5678, 1'b0, 32'h0040_0030, 1'b0, 32'h0},          // R2 add
        '{32'h0C10_0040, 32'h0,         1'b0, 32'h0040_0100, 1'b1, 32'h0040_0034}, // R7 jal
        '{32'h0120_0008, 32'h0FFF_FFFC, 1'b0, 32'h0FFF_FFFC, 1'b0, 32'h0},          // R8 jr
        '{32'h0800_0010, 32'h0,         1'b0, 32'h1000_0040, 1'b0, 32'h0},          // R6 region splice
        '{32'h0120_0009, 32'hDEAD_BEEC, 1'b0, 32'h1000_0044, 1'b0, 32'h0},          // R2/R8 funct 9 ignored
        '{32'h1800_0000, 32'h0,         1'b1, 32'h1000_0048, 1'b0, 32'h0},          // R2 unknown opcode
        '{32'h0C00_0000, 32'h0,         1'b0, 32'h1000_0000, 1'b1, 32'h1000_004C}  // R7 jal in upper region
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check32("R1 reset pc", pc, 32'h0040_0000);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 pc after release", pc, 32'h0040_0000);

        for (int i = 0; i < NV; i++) begin
            instr    = VECS[i].ins;
            rs_val   = VECS[i].rsv;
            rs_equal = VECS[i].eq;
            step_en  = 1'b1;
            #2;
            check32("R2-R8 next_pc", next_pc, VECS[i].exp_pc);
            check32("R10 link_we", {31'd0, link_we}, {31'd0, VECS[i].exp_link});
            if (VECS[i].exp_link) begin
                check32("R7 link_idx", {27'd0, link_idx}, 32'd31);
                check32("R7 link_data", link_data, VECS[i].exp_ldata);
            end
            @(negedge clk);
            check32("R3-R8 pc after step", pc, VECS[i].exp_pc);
        end

        // R9 and R10: hold with a jal present but step low
        step_en = 1'b0;
        instr   = 32'h0C10_0040;
        #2;
        check32("R10 no link without step", {31'd0, link_we}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        check32("R9 pc held", pc, 32'h1000_0000);

        // R1: reset again mid-run
        rst_n = 1'b0;
        #2;
        check32("R1 async reset", pc, 32'h0040_0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 pc after second reset", pc, 32'h0040_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule